// File: doc/BRIEF.md
# Clock Output Start-up and Power-Down Sequencer

This block decides when a clock generator's outputs may run. Once core power is reported valid, it waits for an active-low power-good strobe from the voltage regulator, lets a settle interval pass, and then captures the frequency-select and output-current strap pins a single time. After capture it turns on the PLL enable, waits a fixed hold-off and for PLL lock, and only then lets the divided clocks through to the outputs.

An asynchronous active-low power-down pin is synchronised to the reference clock. When it is asserted, every output clock is closed at its own low phase, so no shortened high pulse appears. The PLL enable is dropped only once every gate is shut. When the pin is released, the PLL is re-enabled and, after lock, all gates open at their next low phase, which keeps the first-to-last restart inside two PCI clock periods. If core power drops, the block returns to the off state at once and forgets the captured straps.

All logic runs on the reference clock. The divided clocks enter as signals that are synchronous to it. The settle and hold-off intervals are counted in reference cycles: about 3580 and 16410 cycles at 14.318 MHz.

Top module: `clkgen_startup_ctrl`

## Requirements
- R1: While reset is high or core power is not valid, the captured straps read zero, the PLL enable is low and every output clock is low.
- R2: With core power valid but the power-good strobe still high, no strap is captured and the PLL enable stays low.
- R3: The straps are captured no earlier than SETTLE_CYC reference cycles after the strobe goes low, and within SETTLE_CYC+6 cycles. The capture is laid out as freq_sel = freq_strap[4:0] and drive_sel = drive_strap[1:0].
- R4: The straps are captured exactly once per power-up. Once they are captured, later changes on the strap pins and on the strobe have no effect on the captured values.
- R5: The PLL enable rises in the cycle the straps are captured, never before. The output clocks stay low until ENWAIT_CYC cycles have passed after capture and PLL lock is high.
- R6: While the power-down pin is held low, the PLL enable goes low once every output is gated, and all output clocks stay low.
- R7: Every high pulse on an output clock has the full high width of its source clock. Gating never produces a shortened pulse (loss of core power excepted).
- R8: After power-down is released, the outputs stay low until lock returns. Then each output produces its first rising edge, and the first-to-last spread is at most two periods of the PCI clock (src_clk[PCI_IDX]).
- R9: A drop of core power during operation clears the straps, the PLL enable and all outputs in the next cycle. A later power-up captures the straps anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| core_pwr_ok | input | 1 | Core power valid, synchronous |
| vr_good_n | input | 1 | Active-low power-good strobe, asynchronous |
| pwr_down_n | input | 1 | Active-low power-down request, asynchronous |
| pll_locked | input | 1 | PLL lock indication |
| freq_strap | input | FS_W | Frequency-select strap pins |
| drive_strap | input | MS_W | Output-current strap pins |
| src_clk | input | N_CLK | Divided clocks, synchronous to clk |
| freq_sel | output | FS_W | Captured frequency straps |
| drive_sel | output | MS_W | Captured current straps |
| pll_enable | output | 1 | VCO/PLL enable |
| clk_out | output | N_CLK | Gated output clocks |

## Verification
The capture path is swept over all 128 combinations of the seven strap bits. Each combination is checked against a lower and an upper timing bound, and again after the pins are inverted and the strobe is toggled. A fault in bit order, in capture timing or in one-shot behaviour therefore shows up for some combination. Power-down is entered at three different phase offsets relative to the divided clocks, so a gate that closes in its high phase is caught by the pulse-width monitor. The restart spread is measured per clock. A last run drops core power during operation and then powers up again with new strap values, which separates clearing from stale capture.

// File: rtl/clkgen_startup_pkg.sv
package clkgen_startup_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_PG,
    ST_SETTLE,
    ST_SAMPLE,
    ST_ENWAIT,
    ST_RUN,
    ST_PDOWN,
    ST_RELOCK
  } seq_state_t;
endpackage

// File: rtl/csc_sync2.sv
module csc_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/csc_gate_cell.sv
module csc_gate_cell (
  input  logic clk,
  input  logic rst,
  input  logic kill,
  input  logic src,
  input  logic en_req,
  output logic en_q,
  output logic gclk_q
);
  logic en_next;
  // the enable may only change while the source is low
  assign en_next = src ? en_q : en_req;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      en_q   <= 1'b0;
      gclk_q <= 1'b0;
    end else begin
      en_q   <= en_next;
      gclk_q <= src & en_next;
    end
  end
endmodule

// File: rtl/csc_seq_fsm.sv
module csc_seq_fsm
  import clkgen_startup_pkg::*;
#(
  parameter int FS_W       = 5,
  parameter int MS_W       = 2,
  parameter int SETTLE_CYC = 3580,
  parameter int ENWAIT_CYC = 16410
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_ok,
  input  logic            pg_s_n,
  input  logic            pd_s_n,
  input  logic            lock,
  input  logic            all_off,
  input  logic [FS_W-1:0] fs_pin,
  input  logic [MS_W-1:0] ms_pin,
  output logic [FS_W-1:0] fs_q,
  output logic [MS_W-1:0] ms_q,
  output logic            sampled_q,
  output logic            pll_en_q,
  output logic            en_req,
  output logic            kill
);
  localparam int MAXC  = (SETTLE_CYC > ENWAIT_CYC) ? SETTLE_CYC : ENWAIT_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] ENWAIT_LAST = CNT_W'(ENWAIT_CYC - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pll_en_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_OFF:     if (pwr_ok) state_d = ST_WAIT_PG;
      ST_WAIT_PG: if (!pg_s_n) begin
                    state_d = ST_SETTLE;
                    cnt_d   = '0;
                  end
      ST_SETTLE:  if (cnt_q == SETTLE_LAST) state_d = ST_SAMPLE;
                  else cnt_d = cnt_q + CNT_W'(1);
      ST_SAMPLE:  begin
                    state_d = ST_ENWAIT;
                    cnt_d   = '0;
                  end
      ST_ENWAIT:  if (cnt_q != ENWAIT_LAST) cnt_d = cnt_q + CNT_W'(1);
                  else if (lock && pd_s_n) state_d = ST_RUN;
      ST_RUN:     if (!pd_s_n) state_d = ST_PDOWN;
      ST_PDOWN:   if (pd_s_n && all_off) state_d = ST_RELOCK;
      ST_RELOCK:  if (!pd_s_n) state_d = ST_PDOWN;
                  else if (lock) state_d = ST_RUN;
      default:    state_d = ST_OFF;
    endcase
    if (!pwr_ok) begin
      state_d = ST_OFF;
      cnt_d   = '0;
    end
  end

  always_comb begin
    unique case (state_d)
      ST_ENWAIT:         pll_en_d = pd_s_n;
      ST_RUN, ST_RELOCK: pll_en_d = 1'b1;
      ST_PDOWN:          pll_en_d = !all_off;
      default:           pll_en_d = 1'b0;
    endcase
  end

  assign en_req = (state_d == ST_RUN);
  assign kill   = (state_d == ST_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_OFF;
      cnt_q     <= '0;
      fs_q      <= '0;
      ms_q      <= '0;
      sampled_q <= 1'b0;
      pll_en_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      pll_en_q <= pll_en_d;
      if (state_d == ST_OFF) begin
        fs_q      <= '0;
        ms_q      <= '0;
        sampled_q <= 1'b0;
      end else if (state_q == ST_SAMPLE) begin
        fs_q      <= fs_pin;
        ms_q      <= ms_pin;
        sampled_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkgen_startup_ctrl.sv
module clkgen_startup_ctrl #(
  parameter int N_CLK      = 4,
  parameter int FS_W       = 5,
  parameter int MS_W       = 2,
  parameter int SETTLE_CYC = 3580,
  parameter int ENWAIT_CYC = 16410
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             core_pwr_ok,
  input  logic             vr_good_n,
  input  logic             pwr_down_n,
  input  logic             pll_locked,
  input  logic [FS_W-1:0]  freq_strap,
  input  logic [MS_W-1:0]  drive_strap,
  input  logic [N_CLK-1:0] src_clk,
  output logic [FS_W-1:0]  freq_sel,
  output logic [MS_W-1:0]  drive_sel,
  output logic             pll_enable,
  output logic [N_CLK-1:0] clk_out
);
  logic             pg_s_n, pd_s_n;
  logic             seq_sampled, en_req, kill;
  logic [N_CLK-1:0] gate_en;

  csc_sync2 #(.W(1), .RST_VAL(1'b1)) u_pg_sync (
    .clk(clk), .rst(rst), .d(vr_good_n), .q(pg_s_n));
  csc_sync2 #(.W(1), .RST_VAL(1'b1)) u_pd_sync (
    .clk(clk), .rst(rst), .d(pwr_down_n), .q(pd_s_n));

  csc_seq_fsm #(
    .FS_W(FS_W), .MS_W(MS_W),
    .SETTLE_CYC(SETTLE_CYC), .ENWAIT_CYC(ENWAIT_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .pwr_ok(core_pwr_ok),
    .pg_s_n(pg_s_n), .pd_s_n(pd_s_n), .lock(pll_locked),
    .all_off(~|gate_en),
    .fs_pin(freq_strap), .ms_pin(drive_strap),
    .fs_q(freq_sel), .ms_q(drive_sel),
    .sampled_q(seq_sampled), .pll_en_q(pll_enable),
    .en_req(en_req), .kill(kill));

  for (genvar i = 0; i < N_CLK; i++) begin : g_gate
    csc_gate_cell u_cell (
      .clk(clk), .rst(rst), .kill(kill),
      .src(src_clk[i]), .en_req(en_req),
      .en_q(gate_en[i]), .gclk_q(clk_out[i]));
  end
endmodule

// File: rtl/clkgen_startup_ctrl_chk.sv
module clkgen_startup_ctrl_chk #(
  parameter int N_CLK = 4,
  parameter int FS_W  = 5,
  parameter int MS_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             core_pwr_ok,
  input logic [N_CLK-1:0] src_clk,
  input logic [N_CLK-1:0] clk_out,
  input logic             pll_enable,
  input logic [FS_W-1:0]  freq_sel,
  input logic [MS_W-1:0]  drive_sel,
  input logic             sampled
);
  // R1, R9: power loss clears everything by the next cycle
  p_off_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !core_pwr_ok |=> (freq_sel == '0 && drive_sel == '0 && !pll_enable && clk_out == '0));

  // R4: captured straps are frozen once capture has happened
  p_strap_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (sampled && $past(sampled)) |-> ($stable(freq_sel) && $stable(drive_sel)));

  // R5: PLL enable never precedes capture
  p_pll_after_sample_r5: assert property (@(posedge clk) disable iff (rst)
    !sampled |-> !pll_enable);

  // R6: with the PLL off, no output runs
  p_gate_low_r6: assert property (@(posedge clk) disable iff (rst)
    !pll_enable |-> (clk_out == '0));

  // R7: an output only falls when its source has fallen
  for (genvar i = 0; i < N_CLK; i++) begin : g_runt
    p_no_runt_r7: assert property (@(posedge clk) disable iff (rst)
      ($fell(clk_out[i]) && $past(core_pwr_ok) && !$past(rst)) |-> !$past(src_clk[i]));
  end
endmodule

bind clkgen_startup_ctrl clkgen_startup_ctrl_chk #(
  .N_CLK(N_CLK), .FS_W(FS_W), .MS_W(MS_W)
) u_chk (
  .clk(clk), .rst(rst), .core_pwr_ok(core_pwr_ok), .src_clk(src_clk),
  .clk_out(clk_out), .pll_enable(pll_enable), .freq_sel(freq_sel),
  .drive_sel(drive_sel), .sampled(seq_sampled));

// File: tb/clkgen_startup_ctrl_test.sv
module clkgen_startup_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int S   = 8;
  localparam int E   = 12;
  localparam int PCI_IDX = 3;
  localparam int PCI_PER = 2 * (PCI_IDX + 1);

  logic clk = 0, rst = 1, pwr_ok = 0, pg_n = 1, pd_n = 1, lock = 0;
  logic [4:0] fs_pin = '0;
  logic [1:0] ms_pin = '0;
  logic [N-1:0] src = '0;
  logic [4:0] fs_q;
  logic [1:0] ms_q;
  logic pll_en;
  logic [N-1:0] gclk;

  int n_tests = 0, n_fail = 0;
  bit done = 0, mon_ignore = 0;

  clkgen_startup_ctrl #(.N_CLK(N), .FS_W(5), .MS_W(2),
    .SETTLE_CYC(S), .ENWAIT_CYC(E)) uut (
    .clk(clk), .rst(rst), .core_pwr_ok(pwr_ok), .vr_good_n(pg_n),
    .pwr_down_n(pd_n), .pll_locked(lock), .freq_strap(fs_pin),
    .drive_strap(ms_pin), .src_clk(src), .freq_sel(fs_q),
    .drive_sel(ms_q), .pll_enable(pll_en), .clk_out(gclk));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // divided source clocks: clock i has half period i+1
  initial begin
    int cnt [N];
    for (int i = 0; i < N; i++) cnt[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (cnt[i] == i) begin
          cnt[i] = 0;
          src[i] = ~src[i];
        end else cnt[i]++;
      end
    end
  end

  // R7 monitor: every output high pulse is full width
  initial begin
    int hi [N];
    for (int i = 0; i < N; i++) hi[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (mon_ignore || rst) hi[i] = 0;
        else if (gclk[i]) hi[i]++;
        else if (hi[i] != 0) begin
          chk(hi[i] == i + 1, "R7 pulse width", hi[i], i + 1);
          hi[i] = 0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(4);
    // R1: reset state
    chk({ms_q, fs_q} == 0, "R1 straps in reset", {ms_q, fs_q}, 0);
    chk(pll_en == 0 && gclk == 0, "R1 pll/out in reset", {pll_en, gclk}, 0);
    rst = 0;

    // exhaustive strap sweep, lock held low
    for (int s = 0; s < 128; s++) begin
      pwr_ok = 0; pg_n = 1; {ms_pin, fs_pin} = 7'(s);
      cyc(3);
      chk({ms_q, fs_q} == 0 && !pll_en && gclk == 0, "R1 power off", {pll_en, ms_q, fs_q}, 0);
      pwr_ok = 1;
      cyc(10);
      chk({ms_q, fs_q} == 0, "R2 no capture before strobe", {ms_q, fs_q}, 0);
      chk(!pll_en, "R2 pll off before strobe", pll_en, 0);
      pg_n = 0;
      cyc(S);
      chk({ms_q, fs_q} == 0, "R3 not before settle", {ms_q, fs_q}, 0);
      chk(!pll_en, "R5 pll off before capture", pll_en, 0);
      cyc(6);
      chk({ms_q, fs_q} == 7'(s), "R3 captured value", {ms_q, fs_q}, s);
      chk(pll_en, "R5 pll on after capture", pll_en, 1);
      {ms_pin, fs_pin} = ~7'(s); pg_n = 1;
      cyc(3);
      pg_n = 0;
      cyc(5);
      chk({ms_q, fs_q} == 7'(s), "R4 capture held", {ms_q, fs_q}, s);
    end

    // full start-up with lock present
    pwr_ok = 0; pg_n = 1; lock = 1; {ms_pin, fs_pin} = 7'h55;
    cyc(3);
    pwr_ok = 1;
    cyc(3);
    pg_n = 0;
    cyc(S + 6);
    for (int c = 0; c < E - 4; c++) begin
      chk(gclk == 0, "R5 outputs held during hold-off", gclk, 0);
      cyc(1);
    end
    begin
      logic [N-1:0] seen = '0;
      for (int c = 0; c < 30; c++) begin
        seen |= gclk;
        cyc(1);
      end
      chk(seen == '1, "R5 outputs running", seen, (1 << N) - 1);
    end

    // power-down at several phases
    for (int k = 0; k < 3; k++) begin
      cyc(k + 1);
      pd_n = 0;
      cyc(20);
      for (int c = 0; c < 10; c++) begin
        chk(!pll_en && gclk == 0, "R6 stopped", {pll_en, gclk}, 0);
        cyc(1);
      end
      lock = 0; pd_n = 1;
      cyc(10);
      chk(pll_en, "R8 pll re-enabled", pll_en, 1);
      chk(gclk == 0, "R8 held until lock", gclk, 0);
      lock = 1;
      begin
        int first [N];
        int mn, mx;
        for (int i = 0; i < N; i++) first[i] = -1;
        for (int c = 0; c < 40; c++) begin
          for (int i = 0; i < N; i++)
            if (gclk[i] && first[i] < 0) first[i] = c;
          cyc(1);
        end
        mn = 1000; mx = -1;
        for (int i = 0; i < N; i++) begin
          chk(first[i] >= 0, "R8 output restarted", first[i], 0);
          if (first[i] < mn) mn = first[i];
          if (first[i] > mx) mx = first[i];
        end
        chk(mx - mn <= 2 * PCI_PER, "R8 restart spread", mx - mn, 2 * PCI_PER);
      end
    end

    // R9: core power loss while running
    cyc(7);
    mon_ignore = 1;
    pwr_ok = 0;
    cyc(1);
    chk({ms_q, fs_q} == 0, "R9 straps cleared", {ms_q, fs_q}, 0);
    chk(!pll_en && gclk == 0, "R9 pll/out cleared", {pll_en, gclk}, 0);
    cyc(2);
    mon_ignore = 0;
    {ms_pin, fs_pin} = 7'h2A;
    pwr_ok = 1;
    cyc(S + 8);
    chk({ms_q, fs_q} == 7'h2A, "R9 fresh capture", {ms_q, fs_q}, 7'h2A);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule